// File: doc/BRIEF.md
# Reciprocal Frequency Meter

This block measures the frequency of an unknown digital signal by the reciprocal method. Software sends a one-cycle arm pulse. The block then waits for a falling edge of the input and opens a measurement gate on that edge. While the gate is open, two counters run side by side. One counts cycles of the block's own clock, which serves as the reference. The other counts falling edges of the input.

The gate stays open until the reference counter has rolled over at least once. After that, the next falling edge of the input closes it. The gate therefore always spans a whole number of input periods. Both counts are then frozen into capture registers and a done flag is raised. Software computes the frequency as f_clk × input_count / reference_span. Because the gate always covers whole input periods, the resolution depends on the reference clock and not on the input frequency.

The input is asynchronous. It passes through a flop synchronizer before edge detection. The reference span can exceed one counter width, so the number of reference rollovers is kept beside the reference count. A flag marks the case where the input counter itself rolled over, which means the input is too fast for its width.

Top module: `recip_freq_meter`

## Requirements
- R1: After reset, busy_o, done_o and too_fast_o are 0, and ref_count_o, ref_wraps_o and sig_count_o are all zero.
- R2: Falling edges on sig_i while no measurement is armed leave busy_o, done_o and all captured outputs unchanged.
- R3: An arm_i pulse in any state makes busy_o 1 and done_o 0 one cycle later. It also clears too_fast_o and the captured outputs, and restarts the measurement. An arm during a running measurement aborts that measurement.
- R4: sig_i passes through SYNC_STAGES synchronizing flops, and the gate opens on the first synchronized falling edge seen after the arm.
- R5: The gate closes on the first input falling edge that occurs strictly after the cycle in which the reference counter first rolls over. For an input period of P clock cycles, sig_count_o holds N = floor(2^REF_W / P) + 1, taken modulo 2^SIG_W.
- R6: The reference span, ref_wraps_o × 2^REF_W + ref_count_o, equals the number of clock cycles between the opening and closing edges (N × P). The reference counter keeps counting through rollovers.
- R7: ref_wraps_o counts every reference-counter rollover while the gate is open and saturates at 2^WRAP_W − 1. In that case ref_count_o still holds the span modulo 2^REF_W.
- R8: too_fast_o is set when the input counter rolls over while the gate is open, and holds until the next arm.
- R9: done_o rises two cycles after the closing edge is detected and stays 1 until the next arm. While done_o is 1, the captured outputs do not change even if sig_i keeps toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also the counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | One-cycle pulse that starts (or restarts) a measurement |
| sig_i | input | 1 | Asynchronous signal under measurement |
| busy_o | output | 1 | Measurement armed or gate open |
| done_o | output | 1 | Captured results valid |
| too_fast_o | output | 1 | Input counter rolled over during the gate |
| ref_count_o | output | REF_W | Captured reference count, modulo 2^REF_W |
| ref_wraps_o | output | WRAP_W | Captured number of reference rollovers (saturating) |
| sig_count_o | output | SIG_W | Captured number of input periods in the gate |

## Verification
The bench uses narrow counters so that rollovers happen quickly.

- **Input periods.** It uses periods that fit the reference window several times, periods longer than one window, and periods long enough to wrap the reference counter two and four times.
  - A design that closes on the edge in the rollover cycle, or counts the opening edge, would be off by one period.
  - A design that stops the reference counter at its first rollover, or lets the rollover count wrap instead of saturating, would report a wrong span.
- **Fast input.** A 4-cycle input overflows the narrow input counter. A design that forgets the overflow, or clears it before the next arm, loses the too-fast flag.
- **Abort.** A re-arm in the middle of a gate must discard the partial counts. A design that does not would report an inflated span.
- **Held results.** The bench watches the captured outputs while the input keeps toggling after done. A design that keeps its counters running would show drifting results.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_OPEN,
        ST_CLOSING,
        ST_CAPT,
        ST_DONE
    } gate_state_t;

endpackage

// File: rtl/rfm_sync_fall.sv
module rfm_sync_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);
    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] pipe_d, pipe_q;

    // pipe_q[STAGES-1] is the synchronized level; pipe_q[STAGES] is its previous value
    always_comb begin
        pipe_d = {pipe_q[PIPE_W-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign fall_o = pipe_q[STAGES] & ~pipe_q[STAGES-1];

endmodule

// File: rtl/rfm_counter.sv
module rfm_counter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
    assign wrap_o  = inc_i & ~clr_i & (&cnt_q);

endmodule

// File: rtl/recip_freq_meter.sv
module recip_freq_meter #(
    parameter int REF_W       = 24,
    parameter int SIG_W       = 24,
    parameter int WRAP_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              sig_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              too_fast_o,
    output logic [REF_W-1:0]  ref_count_o,
    output logic [WRAP_W-1:0] ref_wraps_o,
    output logic [SIG_W-1:0]  sig_count_o
);
    import rfm_pkg::*;

    localparam logic [WRAP_W-1:0] WRAP_MAX = '1;

    typedef struct packed {
        gate_state_t       state;
        logic [WRAP_W-1:0] wraps;
        logic              fast;
        logic              done;
        logic [REF_W-1:0]  ref_cap;
        logic [WRAP_W-1:0] wrap_cap;
        logic [SIG_W-1:0]  sig_cap;
    } regs_t;

    regs_t r_d, r_q;

    logic             fall;
    logic             gate_open;
    logic [REF_W-1:0] ref_cnt;
    logic [SIG_W-1:0] sig_cnt;
    logic             ref_wrap;
    logic             sig_wrap;

    rfm_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sig_i),
        .fall_o  (fall)
    );

    assign gate_open = (r_q.state == ST_OPEN) || (r_q.state == ST_CLOSING);

    rfm_counter #(.W(REF_W)) u_ref_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (arm_i),
        .inc_i   (gate_open),
        .count_o (ref_cnt),
        .wrap_o  (ref_wrap)
    );

    rfm_counter #(.W(SIG_W)) u_sig_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (arm_i),
        .inc_i   (gate_open & fall),
        .count_o (sig_cnt),
        .wrap_o  (sig_wrap)
    );

    always_comb begin
        r_d = r_q;
        if (arm_i) begin
            r_d.state    = ST_ARMED;
            r_d.wraps    = '0;
            r_d.fast     = 1'b0;
            r_d.done     = 1'b0;
            r_d.ref_cap  = '0;
            r_d.wrap_cap = '0;
            r_d.sig_cap  = '0;
        end else begin
            if (ref_wrap && (r_q.wraps != WRAP_MAX)) r_d.wraps = r_q.wraps + 1'b1;
            if (sig_wrap) r_d.fast = 1'b1;
            unique case (r_q.state)
                ST_ARMED:   if (fall) r_d.state = ST_OPEN;
                ST_OPEN:    if (ref_wrap) r_d.state = ST_CLOSING;
                ST_CLOSING: if (fall) r_d.state = ST_CAPT;
                ST_CAPT: begin
                    r_d.ref_cap  = ref_cnt;
                    r_d.sig_cap  = sig_cnt;
                    r_d.wrap_cap = r_q.wraps;
                    r_d.done     = 1'b1;
                    r_d.state    = ST_DONE;
                end
                default: r_d.state = r_q.state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.wraps    <= '0;
            r_q.fast     <= 1'b0;
            r_q.done     <= 1'b0;
            r_q.ref_cap  <= '0;
            r_q.wrap_cap <= '0;
            r_q.sig_cap  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.state != ST_IDLE) && (r_q.state != ST_DONE);
    assign done_o      = r_q.done;
    assign too_fast_o  = r_q.fast;
    assign ref_count_o = r_q.ref_cap;
    assign ref_wraps_o = r_q.wrap_cap;
    assign sig_count_o = r_q.sig_cap;

endmodule

// File: rtl/rfm_chk.sv
module rfm_chk #(
    parameter int REF_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             too_fast_o,
    input logic [REF_W-1:0] ref_count_o
);
    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !arm_i |=> done_o);

    // R9
    cap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !arm_i |=> $stable(ref_count_o));

    // R3
    arm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> busy_o && !done_o && !too_fast_o);

    // R3
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> ref_count_o == '0);

    // R2
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !done_o && !arm_i |=> !busy_o && !done_o);

    // R8
    fast_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(too_fast_o) |-> busy_o);

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
endmodule

bind recip_freq_meter rfm_chk #(.REF_W(REF_W)) u_rfm_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_i       (arm_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .too_fast_o  (too_fast_o),
    .ref_count_o (ref_count_o)
);

// File: tb/sim_recip_freq_meter.sv
module sim_recip_freq_meter;
    localparam int RW = 9;
    localparam int SW = 6;
    localparam int WW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm_i = 1'b0;
    logic sig_i = 1'b0;
    logic busy_o, done_o, too_fast_o;
    logic [RW-1:0] ref_count_o;
    logic [WW-1:0] ref_wraps_o;
    logic [SW-1:0] sig_count_o;

    recip_freq_meter #(.REF_W(RW), .SIG_W(SW), .WRAP_W(WW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .sig_i(sig_i),
        .busy_o(busy_o), .done_o(done_o), .too_fast_o(too_fast_o),
        .ref_count_o(ref_count_o), .ref_wraps_o(ref_wraps_o), .sig_count_o(sig_count_o)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int period = 10;
    int prev_period = 10;
    bit gen_on = 1'b0;

    typedef struct {
        int ref_v;
        int wrap_v;
        int sig_v;
        int fast_v;
    } exp_t;

    exp_t sb_q[$];

    task automatic chk_eq(string req, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic exp_t model(int p);
        exp_t e;
        int n, total, wr;
        n     = (1 << RW) / p + 1;
        total = n * p;
        wr    = total >> RW;
        if (wr > (1 << WW) - 1) wr = (1 << WW) - 1;
        e.ref_v  = total % (1 << RW);
        e.wrap_v = wr;
        e.sig_v  = n % (1 << SW);
        e.fast_v = (n >= (1 << SW)) ? 1 : 0;
        return e;
    endfunction

    // input waveform source, changes away from the active edge
    initial begin
        forever begin
            if (!gen_on) begin
                sig_i = 1'b0;
                @(negedge clk);
            end else begin
                sig_i = 1'b1;
                repeat (period / 2) @(negedge clk);
                sig_i = 1'b0;
                repeat (period - period / 2) @(negedge clk);
            end
        end
    end

    // monitor: compares each completed measurement with the scoreboard
    initial begin
        bit prev_done;
        prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (done_o && !prev_done) begin
                if (sb_q.size() == 0) begin
                    chk_eq("R9", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk_eq("R6", "ref_count", int'(ref_count_o), e.ref_v);
                    chk_eq("R7", "ref_wraps", int'(ref_wraps_o), e.wrap_v);
                    chk_eq("R5", "sig_count", int'(sig_count_o), e.sig_v);
                    chk_eq("R8", "too_fast",  int'(too_fast_o),  e.fast_v);
                end
            end
            prev_done = done_o;
        end
    end

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_up();
    end

    task automatic arm_pulse();
        @(negedge clk);
        arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
        // R3: restart visible one cycle after the arm edge
        chk_eq("R3", "busy after arm", int'(busy_o), 1);
        chk_eq("R3", "done after arm", int'(done_o), 0);
        chk_eq("R3", "too_fast after arm", int'(too_fast_o), 0);
    endtask

    task automatic set_period(int p);
        int settle;
        settle = (p > prev_period) ? p : prev_period;
        period = p;
        gen_on = 1'b1;
        repeat (3 * settle + 4) @(negedge clk);
        prev_period = p;
    endtask

    task automatic wait_drain();
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_meas(int p);
        set_period(p);
        sb_q.push_back(model(p));
        arm_pulse();
        wait_drain();
    endtask

    initial begin
        int r_ref, r_wr, r_sig;
        // R1: reset state
        repeat (5) @(negedge clk);
        chk_eq("R1", "busy", int'(busy_o), 0);
        chk_eq("R1", "done", int'(done_o), 0);
        chk_eq("R1", "too_fast", int'(too_fast_o), 0);
        chk_eq("R1", "ref_count", int'(ref_count_o), 0);
        chk_eq("R1", "sig_count", int'(sig_count_o), 0);
        rst_n = 1'b1;

        // R2: input activity without arm has no effect
        set_period(10);
        repeat (200) @(negedge clk);
        chk_eq("R2", "busy idle", int'(busy_o), 0);
        chk_eq("R2", "done idle", int'(done_o), 0);
        chk_eq("R2", "ref_count idle", int'(ref_count_o), 0);

        // R4 R5 R6: periods shorter than the reference window
        run_meas(10);
        run_meas(37);
        // R6 R7: periods spanning one and two rollovers
        run_meas(700);
        run_meas(1100);
        // R7: rollover count saturates
        run_meas(2100);
        // R8: input counter overflow
        run_meas(4);
        chk_eq("R8", "too_fast held", int'(too_fast_o), 1);

        // R9: results held while the input keeps toggling
        run_meas(37);
        r_ref = int'(ref_count_o);
        r_wr  = int'(ref_wraps_o);
        r_sig = int'(sig_count_o);
        repeat (400) @(negedge clk);
        chk_eq("R9", "done held", int'(done_o), 1);
        chk_eq("R9", "ref stable", int'(ref_count_o), r_ref);
        chk_eq("R9", "wraps stable", int'(ref_wraps_o), r_wr);
        chk_eq("R9", "sig stable", int'(sig_count_o), r_sig);

        // R3: abort mid-gate, then a clean result
        set_period(23);
        arm_pulse();
        repeat (150) @(negedge clk);
        chk_eq("R3", "busy mid gate", int'(busy_o), 1);
        sb_q.push_back(model(23));
        arm_pulse();
        wait_drain();

        finish_up();
    end
endmodule